// File: doc/BRIEF.md
# Cascadable Four-Channel Down-Counting Timer Group

The block holds four periodic down-counters that share one clock prescaler and sit behind a simple 32-bit register bus. Software loads a start value into a timer and then clears that timer's halt flag. From then on the counter steps down once per prescaled tick. When it runs out, it reloads and drives its active-low level interrupt. It keeps running like this until software halts it again or clears its count. Software can read the remaining count at any time.

A group control word sets the prescale ratio. It can also join two neighbouring timers into one long timer. In a joined pair, the lower timer's expiries clock the upper timer. Only the upper timer of the pair raises an interrupt. A per-pair wrap flag chooses what the lower timer reloads between upper steps: either its own start value or the full 32-bit value 0xFFFFFFFF. With the wrap flag set, the total period is the lower start value plus the upper start value times 0xFFFFFFFF.

The bus is a plain register port. A write completes in the clock edge at which `bus_en` and `bus_we` are both high. A read is combinational from `bus_addr` and has no side effects. The bus has no back-pressure and no wait states.

Top module: `tmr_group`

## Requirements
- R1: After reset, every timer's start register reads 0x80000000 (halt set), every count reads 0, the control word reads 0 and all four `irq_n` bits are high.
- R2: Control bits 9:8 pick the prescale ratio: 00 gives one tick every 8 clocks, 01 every 16, 10 every 32 and 11 every 64. The prescale counter runs freely from reset.
- R3: For an unpaired timer, bit 31 of its start register is the halt flag and bits 30:0 are the start value. On the first clock edge at which the flag is clear, the count loads the start value. On each tick after that, the count drops by one. A tick that finds the count at 1 or 0 reloads the start value instead and drives that timer's `irq_n` low.
- R4: Once low, `irq_n` stays low while the timer runs and reloads. It returns high on the clock edge after the halt flag is set, or on the edge of a write to the count register.
- R5: While a timer is halted, its count holds its value.
- R6: Control bit k (k = 0, 1, 2) joins timer k (lower) with timer k+1 (upper). A pair whose lower timer is already the upper timer of an enabled lower-numbered pair is ignored, and that timer then runs unpaired. A lower timer uses all 32 bits of its start register as its start value. It runs under the upper timer's halt flag and never drives its own `irq_n` low.
- R7: In a pair, the upper count drops by one on each lower expiry. A lower expiry that finds the upper count at 0 reloads both timers and drives the upper `irq_n` low. Between upper steps, the lower timer reloads 0xFFFFFFFF when wrap bit 24+k is set, and its own start value otherwise.
- R8: Timer i's registers sit at byte address 64*i: count at +0x00, start at +0x10, vector/priority at +0x20 and destination at +0x30. The control word is at 0x100. The vector/priority and destination registers are plain 32-bit read/write storage.
- R9: Any other address reads 0 and ignores writes. In the control word, only bits 26:24, 9:8 and 2:0 are stored; all other bits read 0.
- R10: A write of any data to a count register clears that count and its interrupt, and the timer reloads on the next edge. In a pair, a count write to either member clears both timers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_en |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_n | output | 4 | Per-timer expiry interrupt, active low, level |

## Verification
A stray count, a missed load or a wrong pairing shows up in the read data and on `irq_n` within one tick. This is at most 64 clocks, because the reference model's count and interrupt level are compared with the ports on every clock. An error in the pair logic is different: it may stay hidden inside the lower timer until that timer's next expiry. The bench therefore keeps pair start values small, so every upper step and every pair interrupt falls within a few dozen clocks. The bench also reads the lower count back directly, to see the wrap reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ROLE_SOLO = 2'd0,
    ROLE_LOW  = 2'd1,
    ROLE_UP   = 2'd2
  } role_e;

  localparam logic [1:0] REG_COUNT = 2'd0;
  localparam logic [1:0] REG_START = 2'd1;
  localparam logic [1:0] REG_VECT  = 2'd2;
  localparam logic [1:0] REG_DEST  = 2'd3;

  localparam int CASC_LSB = 0;
  localparam int DIV_LSB  = 8;
  localparam int WRAP_LSB = 24;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W    = 2,
  parameter int BASE_LOG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int CW = BASE_LOG + (1 << SEL_W) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb limit = CW'((32'd1 << (BASE_LOG + 32'(div_sel))) - 32'd1);

  assign tick = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  role_e         role,
  input  logic          run,
  input  logic          restart,
  input  logic          wrap,
  input  logic [CW-1:0] start_raw,
  input  logic          low_event,
  input  logic          upper_zero,
  output logic [CW-1:0] count,
  output logic          ev_out,
  output logic          irq
);
  localparam logic [CW-1:0] ALL_ONES = '1;

  logic [CW-1:0] start_eff;
  logic          loaded;
  logic          at_end;
  logic          step;

  assign start_eff = (role == ROLE_LOW) ? start_raw : {1'b0, start_raw[CW-2:0]};
  assign at_end    = (count <= CW'(1));
  assign step      = (role == ROLE_UP) ? low_event : tick;
  assign ev_out    = (role == ROLE_LOW) && run && loaded && tick && at_end && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      loaded <= 1'b0;
      irq    <= 1'b0;
    end else if (restart) begin
      count  <= '0;
      loaded <= 1'b0;
      irq    <= 1'b0;
    end else if (!run) begin
      loaded <= 1'b0;
      irq    <= 1'b0;
    end else if (!loaded) begin
      count  <= start_eff;
      loaded <= 1'b1;
    end else begin
      case (role)
        ROLE_LOW: begin
          irq <= 1'b0;
          if (tick) begin
            if (at_end) count <= (upper_zero || !wrap) ? start_eff : ALL_ONES;
            else        count <= count - 1'b1;
          end
        end
        ROLE_UP: begin
          if (low_event) begin
            if (count == '0) begin
              count <= start_eff;
              irq   <= 1'b1;
            end else begin
              count <= count - 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (at_end) begin
              count <= start_eff;
              irq   <= 1'b1;
            end else begin
              count <= count - 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_HALT_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq); // R4
  AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(count)); // R5
  AST_SOLO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_SOLO && run && loaded && tick && !at_end && !restart)
      |=> (count == $past(count) - 1'b1)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(step)); // R7
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pkg::*; #(
  parameter int NUM = 4,
  parameter int CW  = 32,
  parameter int WIN_LOG = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [WIN_LOG+$clog2(NUM):0]  bus_addr,
  input  logic [CW-1:0]                 bus_wdata,
  output logic [CW-1:0]                 bus_rdata,
  input  logic [NUM-1:0][CW-1:0]        counts,
  output logic [NUM-1:0][CW-1:0]        start,
  output logic [NUM-2:0]                casc,
  output logic [NUM-2:0]                wrap,
  output logic [1:0]                    div_sel,
  output logic [NUM-1:0]                cnt_wr
);
  localparam int IDX_W = $clog2(NUM);
  localparam int AW    = WIN_LOG + IDX_W + 1;
  localparam int NP    = NUM - 1;
  localparam logic [CW-1:0] START_RST = {1'b1, {(CW-1){1'b0}}};

  logic             wr;
  logic             grp_hit;
  logic             win_hit;
  logic [IDX_W-1:0] tsel;
  logic [1:0]       rsel;
  logic [CW-1:0]    ctrl_word;
  logic [NUM-1:0][CW-1:0] vect;
  logic [NUM-1:0][CW-1:0] dest;

  assign wr      = bus_en && bus_we;
  assign grp_hit = bus_addr[AW-1] && (bus_addr[AW-2:0] == '0);
  assign win_hit = !bus_addr[AW-1] && (bus_addr[WIN_LOG-3:0] == '0);
  assign tsel    = bus_addr[AW-2:WIN_LOG];
  assign rsel    = bus_addr[WIN_LOG-1:WIN_LOG-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      casc    <= '0;
      wrap    <= '0;
      div_sel <= 2'b00;
    end else if (wr && grp_hit) begin
      casc    <= bus_wdata[CASC_LSB +: NP];
      wrap    <= bus_wdata[WRAP_LSB +: NP];
      div_sel <= bus_wdata[DIV_LSB +: 2];
    end
  end

  for (genvar i = 0; i < NUM; i++) begin : g_win
    logic sel_i;
    assign sel_i     = wr && win_hit && (tsel == IDX_W'(i));
    assign cnt_wr[i] = sel_i && (rsel == REG_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start[i] <= START_RST;
        vect[i]  <= '0;
        dest[i]  <= '0;
      end else if (sel_i) begin
        if (rsel == REG_START) start[i] <= bus_wdata;
        if (rsel == REG_VECT)  vect[i]  <= bus_wdata;
        if (rsel == REG_DEST)  dest[i]  <= bus_wdata;
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CASC_LSB +: NP] = casc;
    ctrl_word[WRAP_LSB +: NP] = wrap;
    ctrl_word[DIV_LSB +: 2]   = div_sel;
  end

  always_comb begin
    bus_rdata = '0;
    if (grp_hit) begin
      bus_rdata = ctrl_word;
    end else if (win_hit) begin
      case (rsel)
        REG_COUNT: bus_rdata = counts[tsel];
        REG_START: bus_rdata = start[tsel];
        REG_VECT:  bus_rdata = vect[tsel];
        default:   bus_rdata = dest[tsel];
      endcase
    end
  end
endmodule

// File: rtl/tmr_group.sv
module tmr_group import tmr_pkg::*; #(
  parameter int NUM     = 4,
  parameter int CW      = 32,
  parameter int WIN_LOG = 6,
  parameter int PRE_LOG = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_en,
  input  logic                             bus_we,
  input  logic [WIN_LOG+$clog2(NUM):0]     bus_addr,
  input  logic [CW-1:0]                    bus_wdata,
  output logic [CW-1:0]                    bus_rdata,
  output logic [NUM-1:0]                   irq_n
);
  localparam int NP = NUM - 1;

  logic [NUM-1:0][CW-1:0] counts;
  logic [NUM-1:0][CW-1:0] start;
  logic [NP-1:0]          casc;
  logic [NP-1:0]          wrap;
  logic [NP-1:0]          pair_on;
  logic [1:0]             div_sel;
  logic [NUM-1:0]         cnt_wr;
  logic [NUM-1:0]         ev;
  logic [NUM-1:0]         irq;
  logic                   tick;
  logic                   prev_on;
  role_e                  role [NUM];

  tmr_regs #(.NUM(NUM), .CW(CW), .WIN_LOG(WIN_LOG)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .counts    (counts),
    .start     (start),
    .casc      (casc),
    .wrap      (wrap),
    .div_sel   (div_sel),
    .cnt_wr    (cnt_wr)
  );

  tmr_prescaler #(.SEL_W(2), .BASE_LOG(PRE_LOG)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .tick    (tick)
  );

  // lowest pair wins when two enabled pairs share a timer
  always_comb begin
    prev_on = 1'b0;
    for (int k = 0; k < NP; k++) begin
      pair_on[k] = casc[k] && !prev_on;
      prev_on    = pair_on[k];
    end
    for (int i = 0; i < NUM; i++) role[i] = ROLE_SOLO;
    for (int k = 0; k < NP; k++) begin
      if (pair_on[k]) begin
        role[k]   = ROLE_LOW;
        role[k+1] = ROLE_UP;
      end
    end
  end

  for (genvar i = 0; i < NUM; i++) begin : g_ch
    logic run_c;
    logic restart_c;
    logic low_ev_c;
    logic up_zero_c;
    logic wrap_c;
    logic wr_up_c;
    logic wr_lo_c;
    logic halt_up_c;

    if (i < NUM - 1) begin : g_has_up
      assign up_zero_c = (counts[i+1] == '0);
      assign wrap_c    = wrap[i];
      assign wr_up_c   = cnt_wr[i+1];
      assign halt_up_c = start[i+1][CW-1];
    end else begin : g_no_up
      assign up_zero_c = 1'b0;
      assign wrap_c    = 1'b0;
      assign wr_up_c   = 1'b0;
      assign halt_up_c = 1'b1;
    end

    if (i > 0) begin : g_has_lo
      assign low_ev_c = ev[i-1];
      assign wr_lo_c  = cnt_wr[i-1];
    end else begin : g_no_lo
      assign low_ev_c = 1'b0;
      assign wr_lo_c  = 1'b0;
    end

    assign run_c     = (role[i] == ROLE_LOW) ? !halt_up_c : !start[i][CW-1];
    assign restart_c = cnt_wr[i] || ((role[i] == ROLE_LOW) && wr_up_c)
                                 || ((role[i] == ROLE_UP) && wr_lo_c);

    tmr_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .role       (role[i]),
      .run        (run_c),
      .restart    (restart_c),
      .wrap       (wrap_c),
      .start_raw  (start[i]),
      .low_event  (low_ev_c),
      .upper_zero (up_zero_c),
      .count      (counts[i]),
      .ev_out     (ev[i]),
      .irq        (irq[i])
    );

    assign irq_n[i] = !irq[i];
  end
endmodule

// File: tb/sim_tmr_group.sv
module sim_tmr_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_n;

  always #5 clk = ~clk;

  tmr_group u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_cnt [4], m_st [4], m_vec [4], m_dst [4];
  logic [31:0] n_cnt [4];
  bit          m_ld [4], m_irq [4], n_ld [4], n_irq [4];
  bit          m_run [4], m_rs [4], m_ev [4], m_cw [4], m_pair [3];
  int          m_role [4];
  logic [31:0] m_ctrl;
  int          m_pre, m_div;
  bit          m_tk, prv;

  function automatic logic [31:0] m_read(logic [8:0] a);
    if (a[8]) return (a[7:0] == 8'd0) ? m_ctrl : 32'd0;
    if (a[3:0] != 4'd0) return 32'd0;
    case (a[5:4])
      2'd0: return m_cnt[a[7:6]];
      2'd1: return m_st[a[7:6]];
      2'd2: return m_vec[a[7:6]];
      default: return m_dst[a[7:6]];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = 0; m_st[i] = 32'h8000_0000; m_vec[i] = 0; m_dst[i] = 0;
        m_ld[i] = 0; m_irq[i] = 0;
      end
      m_ctrl = 0; m_pre = 0;
    end else begin
      m_div = 8 << m_ctrl[9:8];
      m_tk  = (m_pre >= m_div - 1);
      prv = 0;
      for (int k = 0; k < 3; k++) begin m_pair[k] = m_ctrl[k] && !prv; prv = m_pair[k]; end
      for (int i = 0; i < 4; i++) m_role[i] = 0;
      for (int k = 0; k < 3; k++) if (m_pair[k]) begin m_role[k] = 1; m_role[k+1] = 2; end
      for (int i = 0; i < 4; i++)
        m_cw[i] = bus_en && bus_we && !bus_addr[8] && bus_addr[3:0] == 0 &&
                  bus_addr[7:6] == i[1:0] && bus_addr[5:4] == 0;
      for (int i = 0; i < 4; i++) begin
        int hi, lo;
        hi = (i < 3) ? i + 1 : i;
        lo = (i > 0) ? i - 1 : i;
        m_run[i] = (m_role[i] == 1) ? !m_st[hi][31] : !m_st[i][31];
        m_rs[i]  = m_cw[i] || (m_role[i] == 1 && m_cw[hi]) || (m_role[i] == 2 && m_cw[lo]);
      end
      for (int i = 0; i < 4; i++)
        m_ev[i] = m_role[i] == 1 && m_run[i] && m_ld[i] && m_tk && m_cnt[i] <= 1 && !m_rs[i];
      for (int i = 0; i < 4; i++) begin
        int hi, lo;
        logic [31:0] be;
        hi = (i < 3) ? i + 1 : i;
        lo = (i > 0) ? i - 1 : i;
        be = (m_role[i] == 1) ? m_st[i] : {1'b0, m_st[i][30:0]};
        n_cnt[i] = m_cnt[i]; n_ld[i] = m_ld[i]; n_irq[i] = m_irq[i];
        if (m_rs[i]) begin n_cnt[i] = 0; n_ld[i] = 0; n_irq[i] = 0; end
        else if (!m_run[i]) begin n_ld[i] = 0; n_irq[i] = 0; end
        else if (!m_ld[i]) begin n_cnt[i] = be; n_ld[i] = 1; end
        else if (m_role[i] == 1) begin
          n_irq[i] = 0;
          if (m_tk) begin
            if (m_cnt[i] <= 1) n_cnt[i] = (m_cnt[hi] == 0 || !m_ctrl[24+i]) ? be : 32'hFFFF_FFFF;
            else n_cnt[i] = m_cnt[i] - 1;
          end
        end else if (m_role[i] == 2) begin
          if (m_ev[lo]) begin
            if (m_cnt[i] == 0) begin n_cnt[i] = be; n_irq[i] = 1; end
            else n_cnt[i] = m_cnt[i] - 1;
          end
        end else if (m_tk) begin
          if (m_cnt[i] <= 1) begin n_cnt[i] = be; n_irq[i] = 1; end
          else n_cnt[i] = m_cnt[i] - 1;
        end
      end
      for (int i = 0; i < 4; i++) begin m_cnt[i] = n_cnt[i]; m_ld[i] = n_ld[i]; m_irq[i] = n_irq[i]; end
      if (bus_en && bus_we) begin
        if (bus_addr[8]) begin
          if (bus_addr[7:0] == 0) m_ctrl = bus_wdata & 32'h0700_0307;
        end else if (bus_addr[3:0] == 0) begin
          case (bus_addr[5:4])
            2'd1: m_st[bus_addr[7:6]]  = bus_wdata;
            2'd2: m_vec[bus_addr[7:6]] = bus_wdata;
            2'd3: m_dst[bus_addr[7:6]] = bus_wdata;
            default: ;
          endcase
        end
      end
      m_pre = m_tk ? 0 : m_pre + 1;
    end
  end

  // every-clock comparison of ports against the model
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      logic [3:0] exp_irq;
      for (int i = 0; i < 4; i++) exp_irq[i] = !m_irq[i];
      n_cmp++;
      if (irq_n !== exp_irq) begin
        n_bad++;
        $display("FAIL %s irq_n act=%h exp=%h t=%0t", cur_req, irq_n, exp_irq, $time);
      end
      n_cmp++;
      if (bus_rdata !== m_read(bus_addr)) begin
        n_bad++;
        $display("FAIL %s rdata@%h act=%h exp=%h t=%0t", cur_req, bus_addr, bus_rdata,
                 m_read(bus_addr), $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic measure(input int exp_gap, input string tag);
    logic [31:0] prev, cur;
    int times [3];
    int k, cyc;
    k = 0; cyc = 0;
    rd(9'h0C0, prev);
    while (k < 3 && cyc < 400) begin
      rd(9'h0C0, cur);
      cyc++;
      if (cur != prev) begin times[k] = cyc; k++; end
      prev = cur;
    end
    chk(tag, 32'(times[2] - times[1]), 32'(exp_gap));
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    for (int i = 0; i < 4; i++) begin
      rd(9'(64 * i + 16), v); chk("R1 start reset", v, 32'h8000_0000);
      rd(9'(64 * i), v);      chk("R1 count reset", v, 32'h0);
    end
    rd(9'h100, v); chk("R1 ctrl reset", v, 32'h0);
    chk("R1 irq_n reset", {28'd0, irq_n}, 32'hF);

    cur_req = "R8";
    wr(9'h0A0, 32'h1234_5678);
    wr(9'h0F0, 32'hCAFE_0001);
    rd(9'h0A0, v); chk("R8 vector store", v, 32'h1234_5678);
    rd(9'h0F0, v); chk("R8 dest store", v, 32'hCAFE_0001);
    rd(9'h020, v); chk("R8 other vector untouched", v, 32'h0);

    cur_req = "R9";
    wr(9'h004, 32'hFFFF_FFFF);
    rd(9'h004, v); chk("R9 reserved reads 0", v, 32'h0);
    rd(9'h000, v); chk("R9 count untouched", v, 32'h0);
    wr(9'h014, 32'h5);
    rd(9'h010, v); chk("R9 start untouched", v, 32'h8000_0000);
    wr(9'h104, 32'h5);
    rd(9'h104, v); chk("R9 reserved group", v, 32'h0);
    wr(9'h100, 32'hFFFF_FFFF);
    rd(9'h100, v); chk("R9 ctrl mask", v, 32'h0700_0307);
    wr(9'h100, 32'h0);

    cur_req = "R3";
    wr(9'h010, 32'h3);
    rd(9'h000, v); chk("R3 load on first edge", v, 32'h3);
    repeat (40) @(negedge clk);
    chk("R3 expiry irq", {31'd0, irq_n[0]}, 32'h0);

    cur_req = "R2";
    wr(9'h100, 32'h100);
    wr(9'h0D0, 32'd200);
    measure(16, "R2 div16");
    wr(9'h100, 32'h300);
    measure(64, "R2 div64");
    wr(9'h100, 32'h0);
    measure(8, "R2 div8");

    cur_req = "R4";
    wr(9'h010, 32'h8000_0003);
    @(negedge clk);
    chk("R4 halt clears irq", {31'd0, irq_n[0]}, 32'h1);
    cur_req = "R5";
    rd(9'h000, v);
    repeat (40) @(negedge clk);
    rd(9'h000, v2);
    chk("R5 count held", v2, v);

    cur_req = "R4";
    wr(9'h0C0, 32'h0);
    wr(9'h0D0, 32'h2);
    wr(9'h0C0, 32'h0);
    repeat (30) @(negedge clk);
    chk("R4 irq low", {31'd0, irq_n[3]}, 32'h0);
    repeat (30) @(negedge clk);
    chk("R4 irq stays low", {31'd0, irq_n[3]}, 32'h0);
    cur_req = "R10";
    wr(9'h0C0, 32'h0000_FFFF);
    chk("R10 count write clears irq", {31'd0, irq_n[3]}, 32'h1);
    wr(9'h0D0, 32'h8000_0002);

    cur_req = "R6";
    wr(9'h100, 32'h1);
    wr(9'h010, 32'h8000_0005);
    wr(9'h050, 32'h1);
    rd(9'h000, v); chk("R6 lower full 32-bit start", v, 32'h8000_0005);
    cur_req = "R7";
    wr(9'h010, 32'h2);
    wr(9'h040, 32'h0);
    repeat (50) @(negedge clk);
    chk("R7 pair irq on upper", {31'd0, irq_n[1]}, 32'h0);
    chk("R6 lower irq silent", {31'd0, irq_n[0]}, 32'h1);
    cur_req = "R10";
    wr(9'h000, 32'h1);
    chk("R10 pair restart clears upper irq", {31'd0, irq_n[1]}, 32'h1);

    cur_req = "R6";
    wr(9'h100, 32'h3);
    wr(9'h090, 32'h3);
    repeat (40) @(negedge clk);
    chk("R6 overlapped pair ignored", {31'd0, irq_n[2]}, 32'h0);
    wr(9'h090, 32'h8000_0003);
    wr(9'h050, 32'h8000_0001);

    cur_req = "R7";
    wr(9'h100, 32'h0200_0002);
    wr(9'h050, 32'h2);
    wr(9'h090, 32'h3);
    repeat (40) @(negedge clk);
    rd(9'h040, v); chk("R7 wrap reload", {31'd0, v >= 32'hFFFF_FFF0}, 32'h1);
    rd(9'h080, v); chk("R7 upper stepped", v, 32'h2);
    chk("R7 no early irq", {31'd0, irq_n[2]}, 32'h1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule